// File: doc/BRIEF.md
# Memory test pattern sequencer

The block runs a self-contained test of a small synchronous SRAM with 16 locations of 8 bits each. After a start pulse it takes over the address, write data and the write and read strobes of the memory. It then works through three phases in a fixed order. It compares each word read back against the value the phase expects, and stops at the first word that differs.

The first phase checks the data lines. It walks a single one across the data word at one fixed address, and reads each write back at once. The second phase checks the address lines. It writes a probe pattern to every power-of-two address and its complement to address zero. Reading the probes back exposes any address line that aliases one location onto another. The third phase checks every cell. It fills the whole array with the offset plus one and verifies it, then fills it again with the complement of that value and verifies that, so that every bit is seen holding both a one and a zero.

When the run ends the block raises done. On a mismatch it also raises fail and holds a phase code, the failing address, the expected word and the word actually read, until the next start.

Top module: `memtest_seq`

## Requirements
- R1: While reset is held and directly after it, done_o, fail_o, busy_o, mem_we_o and mem_re_o are 0, and fail_phase_o, fail_addr_o, fail_exp_o and fail_act_o are 0.
- R2: The first phase makes 16 accesses: for i = 0 to 7, a write of 1<<i to address 0, followed directly by a read of address 0 that expects 1<<i.
- R3: An access is one cycle with exactly one strobe high, followed by one cycle with both strobes low and the same address. Read data is compared at the end of that second cycle.
- R4: The second phase makes 10 accesses, in this order: writes of 8'hAA to addresses 1, 2, 4 and 8; a write of 8'h55 to address 0; reads of 1, 2, 4 and 8 that expect 8'hAA; a read of address 0 that expects 8'h55. It touches no other address.
- R5: The third phase makes 64 accesses: writes of a+1 to each address a from 0 to 15, then reads of a from 0 to 15 that expect a+1, then writes of ~(a+1) for a from 0 to 15, then reads of a from 0 to 15 that expect ~(a+1).
- R6: A run with no mismatch makes exactly 90 accesses over 180 busy cycles. It then shows done_o=1, fail_o=0 and busy_o=0.
- R7: After a mismatch the block makes no further access. It raises done_o and fail_o together and sets fail_phase_o to 1 for the data phase, 2 for the address phase or 3 for the cell phase.
- R8: On a mismatch, fail_addr_o holds the address that was read, fail_exp_o the expected word and fail_act_o the word returned.
- R9: A start pulse while busy_o is high is ignored: the access sequence and its length do not change.
- R10: A start pulse while done_o is high begins a new run. In the next cycle busy_o=1, done_o=0 and fail_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a run when the block is idle or done |
| mem_addr_o | output | 4 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe; the memory returns data on the next cycle |
| mem_rdata_i | input | 8 | Registered read data from the memory |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has ended |
| fail_o | output | 1 | The run ended on a mismatch |
| fail_phase_o | output | 2 | Phase of the mismatch: 1 data, 2 address, 3 cell |
| fail_addr_o | output | 4 | Address of the mismatch |
| fail_exp_o | output | 8 | Expected word |
| fail_act_o | output | 8 | Word read back |

## Verification
The bench drives a memory model into which it can inject faults: a data bit stuck at 0 on writes, a data bit stuck at 1 on reads, an address bit stuck at 0, and a single cell bit that cannot hold a one. Each fault is chosen so that a different phase catches it, and at a known access. A sequencer with a wrong phase order, wrong probe addresses or a wrong complement pass would either miss the fault or report it at another address, phase or data pair. A design that kept going after the mismatch would produce accesses the scoreboard does not expect. A start pulse in the middle of a clean run checks that a busy sequencer does not restart: restarting would lengthen the run past 180 busy cycles. Restarting from the done state checks that the previous failure record is cleared.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_DATA = 2'd1,
    PH_ADDR = 2'd2,
    PH_CELL = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_DONE   = 2'd3
  } state_e;

endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int STEP_W = 6,
  parameter logic [ADDR_W-1:0] DB_ADDR = '0,
  parameter logic [DATA_W-1:0] PROBE_PAT = {(DATA_W/2){2'b10}}
) (
  input  phase_e              phase_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic                is_write_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                last_o
);
  localparam int DEPTH = 1 << ADDR_W;

  always_comb begin
    int s, q, a, k;
    logic [DATA_W-1:0] v;
    s = int'(step_i);
    q = s / DEPTH;
    a = s % DEPTH;
    k = s - ADDR_W - 1;
    v = DATA_W'(a + 1);
    is_write_o = 1'b0;
    addr_o     = '0;
    data_o     = '0;
    last_o     = 1'b0;
    unique case (phase_i)
      PH_DATA: begin
        is_write_o = (s % 2) == 0;
        addr_o     = DB_ADDR;
        data_o     = DATA_W'(1) << (s / 2);
        last_o     = s == 2 * DATA_W - 1;
      end
      PH_ADDR: begin
        if (s < ADDR_W) begin
          is_write_o = 1'b1;
          addr_o     = ADDR_W'(1) << s;
          data_o     = PROBE_PAT;
        end else if (s == ADDR_W) begin
          is_write_o = 1'b1;
          data_o     = ~PROBE_PAT;
        end else if (s <= 2 * ADDR_W) begin
          addr_o     = ADDR_W'(1) << k;
          data_o     = PROBE_PAT;
        end else begin
          data_o     = ~PROBE_PAT;
        end
        last_o = s == 2 * ADDR_W + 1;
      end
      PH_CELL: begin
        is_write_o = (q % 2) == 0;
        addr_o     = ADDR_W'(a);
        data_o     = (q >= 2) ? ~v : v;
        last_o     = s == 4 * DEPTH - 1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              mismatch_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output state_e            state_o,
  output logic              accept_o
);
  state_e            state_q;
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;

  assign accept_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_NONE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept_o) begin
            state_q <= ST_SETUP;
            phase_q <= PH_DATA;
            step_q  <= '0;
          end
        end
        ST_SETUP: state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (mismatch_i) begin
            state_q <= ST_DONE;
          end else if (last_i) begin
            step_q <= '0;
            unique case (phase_q)
              PH_DATA: begin phase_q <= PH_ADDR; state_q <= ST_SETUP; end
              PH_ADDR: begin phase_q <= PH_CELL; state_q <= ST_SETUP; end
              default: state_q <= ST_DONE;
            endcase
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_SETUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign state_o = state_q;
endmodule

// File: rtl/memtest_result.sv
module memtest_result
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] act_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [1:0]        phase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] act_o
);
  assign mismatch_o = sample_i && (act_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o  <= 1'b0;
      phase_o <= '0;
      addr_o  <= '0;
      exp_o   <= '0;
      act_o   <= '0;
    end else if (clear_i) begin
      fail_o  <= 1'b0;
      phase_o <= '0;
      addr_o  <= '0;
      exp_o   <= '0;
      act_o   <= '0;
    end else if (mismatch_o) begin
      fail_o  <= 1'b1;
      phase_o <= phase_i;
      addr_o  <= addr_i;
      exp_o   <= exp_i;
      act_o   <= act_i;
    end
  end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [1:0]        fail_phase_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int DB_STEPS  = 2 * DATA_W;
  localparam int AB_STEPS  = 2 * ADDR_W + 2;
  localparam int DV_STEPS  = 4 * DEPTH;
  localparam int MAX_A     = (DB_STEPS > AB_STEPS) ? DB_STEPS : AB_STEPS;
  localparam int MAX_STEPS = (MAX_A > DV_STEPS) ? MAX_A : DV_STEPS;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  phase_e            phase;
  state_e            state;
  logic [STEP_W-1:0] step;
  logic              accept, last, mismatch, is_write;
  logic [ADDR_W-1:0] pat_addr;
  logic [DATA_W-1:0] pat_data;

  memtest_ctrl #(.STEP_W(STEP_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .last_i    (last),
    .mismatch_i(mismatch),
    .phase_o   (phase),
    .step_o    (step),
    .state_o   (state),
    .accept_o  (accept)
  );

  memtest_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) i_pattern (
    .phase_i   (phase),
    .step_i    (step),
    .is_write_o(is_write),
    .addr_o    (pat_addr),
    .data_o    (pat_data),
    .last_o    (last)
  );

  memtest_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .sample_i  (state == ST_SAMPLE && !is_write),
    .phase_i   (phase),
    .addr_i    (pat_addr),
    .exp_i     (pat_data),
    .act_i     (mem_rdata_i),
    .mismatch_o(mismatch),
    .fail_o    (fail_o),
    .phase_o   (fail_phase_o),
    .addr_o    (fail_addr_o),
    .exp_o     (fail_exp_o),
    .act_o     (fail_act_o)
  );

  assign busy_o      = (state == ST_SETUP) || (state == ST_SAMPLE);
  assign done_o      = state == ST_DONE;
  assign mem_addr_o  = busy_o ? pat_addr : '0;
  assign mem_wdata_o = (busy_o && is_write) ? pat_data : '0;
  assign mem_we_o    = (state == ST_SETUP) && is_write;
  assign mem_re_o    = (state == ST_SETUP) && !is_write;
endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [1:0]        fail_phase_o
);
  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |=> (!mem_we_o && !mem_re_o && $stable(mem_addr_o)));

  p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_we_o && !mem_re_o));

  p_fail_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  p_fail_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_phase_o != 2'd0));

  p_busy_needs_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (busy_o && !done_o && !fail_o));
endmodule

bind memtest_seq memtest_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_phase_o(fail_phase_o)
);

// File: tb/test_memtest_seq.sv
module test_memtest_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic       mem_we_o, mem_re_o;
  logic [7:0] mem_rdata_i = '0;
  logic       busy_o, done_o, fail_o;
  logic [1:0] fail_phase_o;
  logic [3:0] fail_addr_o;
  logic [7:0] fail_exp_o, fail_act_o;

  always #5 clk_i = ~clk_i;

  memtest_seq i_memtest_seq (.*);

  // memory model with injectable faults
  logic [7:0] mem [16];
  logic [7:0] f_wclr = '0, f_rset = '0, f_cclr = '0;
  logic [3:0] f_aclr = '0, f_caddr = '0;
  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk_i) begin
    logic [3:0] a;
    logic [7:0] d;
    a = mem_addr_o & ~f_aclr;
    d = mem_wdata_o & ~f_wclr;
    if (a == f_caddr) d = d & ~f_cclr;
    if (mem_we_o) mem[a] <= d;
    if (mem_re_o) mem_rdata_i <= mem[a] | f_rset;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {bit w; logic [3:0] a; logic [7:0] d; string req;} item_t;
  item_t exp_q[$];
  int n_acc = 0, busy_cyc = 0;
  bit prev_stb = 0;
  logic [3:0] prev_addr = '0;

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o) busy_cyc++;
      if (prev_stb) begin
        chk(!(mem_we_o || mem_re_o), "R3", "strobe held two cycles", {mem_we_o, mem_re_o}, 0);
        chk(mem_addr_o == prev_addr, "R3", "address not held", mem_addr_o, prev_addr);
      end
      if (mem_we_o && mem_re_o) chk(0, "R3", "both strobes", 3, 1);
      if (mem_we_o || mem_re_o) begin
        n_acc++;
        if (exp_q.size() == 0) begin
          chk(0, "R7", "unexpected access at address", mem_addr_o, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mem_we_o == it.w, it.req, "access kind", mem_we_o, it.w);
          chk(mem_addr_o == it.a, it.req, "access address", mem_addr_o, it.a);
          if (it.w) chk(mem_wdata_o == it.d, it.req, "write data", mem_wdata_o, it.d);
        end
      end
      prev_stb  = mem_we_o || mem_re_o;
      prev_addr = mem_addr_o;
    end
  end

  // driver: push the first `limit` accesses of a clean run
  task automatic push(bit w, int a, int d, string req, inout int left);
    item_t it;
    if (left <= 0) return;
    it.w = w; it.a = 4'(a); it.d = 8'(d); it.req = req;
    exp_q.push_back(it);
    left--;
  endtask

  task automatic build_expected(int limit);
    int left = limit;
    exp_q.delete();
    for (int i = 0; i < 8; i++) begin
      push(1, 0, 1 << i, "R2", left);
      push(0, 0, 1 << i, "R2", left);
    end
    for (int k = 0; k < 4; k++) push(1, 1 << k, 8'hAA, "R4", left);
    push(1, 0, 8'h55, "R4", left);
    for (int k = 0; k < 4; k++) push(0, 1 << k, 8'hAA, "R4", left);
    push(0, 0, 8'h55, "R4", left);
    for (int a = 0; a < 16; a++) push(1, a, a + 1, "R5", left);
    for (int a = 0; a < 16; a++) push(0, a, a + 1, "R5", left);
    for (int a = 0; a < 16; a++) push(1, a, ~(a + 1), "R5", left);
    for (int a = 0; a < 16; a++) push(0, a, ~(a + 1), "R5", left);
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic run_case(string name, int limit, bit mid_start, bit exp_fail,
                          int ph, int fa, int fe, int fx);
    int waited = 0;
    build_expected(limit);
    n_acc = 0; busy_cyc = 0;
    pulse_start();
    chk(busy_o && !done_o && !fail_o, "R10", {name, " state after start"},
        {busy_o, done_o, fail_o}, 3'b100);
    if (mid_start) begin
      repeat (40) @(negedge clk_i);
      pulse_start();
    end
    while (!done_o && waited < 1000) begin
      @(negedge clk_i);
      waited++;
    end
    chk(done_o, exp_fail ? "R7" : "R6", {name, " done"}, done_o, 1);
    chk(fail_o == exp_fail, exp_fail ? "R7" : "R6", {name, " fail flag"}, fail_o, exp_fail);
    chk(!busy_o, "R6", {name, " busy after end"}, busy_o, 0);
    if (exp_fail) begin
      chk(fail_phase_o == 2'(ph), "R7", {name, " phase code"}, fail_phase_o, ph);
      chk(fail_addr_o == 4'(fa), "R8", {name, " fail address"}, fail_addr_o, fa);
      chk(fail_exp_o == 8'(fe), "R8", {name, " expected word"}, fail_exp_o, fe);
      chk(fail_act_o == 8'(fx), "R8", {name, " actual word"}, fail_act_o, fx);
    end else begin
      chk(busy_cyc == 180, mid_start ? "R9" : "R6", {name, " busy cycles"}, busy_cyc, 180);
    end
    repeat (8) @(negedge clk_i);
    chk(exp_q.size() == 0, exp_fail ? "R7" : "R6", {name, " accesses left over"}, exp_q.size(), 0);
    chk(n_acc == limit, exp_fail ? "R7" : "R6", {name, " access count"}, n_acc, limit);
    f_wclr = '0; f_rset = '0; f_aclr = '0; f_cclr = '0; f_caddr = '0;
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk_i);
    chk({done_o, fail_o, busy_o, mem_we_o, mem_re_o} == 0, "R1", "flags in reset",
        {done_o, fail_o, busy_o, mem_we_o, mem_re_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({done_o, fail_o, busy_o, mem_we_o, mem_re_o} == 0, "R1", "flags after reset",
        {done_o, fail_o, busy_o, mem_we_o, mem_re_o}, 0);
    chk({fail_phase_o, fail_addr_o, fail_exp_o, fail_act_o} == 0, "R1", "record after reset",
        {fail_phase_o, fail_addr_o, fail_exp_o, fail_act_o}, 0);

    // clean run, start pulse mid-run must be ignored (R9)
    run_case("clean", 90, 1, 0, 0, 0, 0, 0);
    // write data bit 3 stuck at 0: data phase, read of 0x08
    f_wclr = 8'h08;
    run_case("wbit3", 8, 0, 1, 1, 0, 8'h08, 8'h00);
    // read data bit 0 stuck at 1: data phase, read of 0x02
    f_rset = 8'h01;
    run_case("rbit0", 4, 0, 1, 1, 0, 8'h02, 8'h03);
    // address bit 2 stuck at 0: address phase, probe 4 aliases 0
    f_aclr = 4'h4;
    run_case("abit2", 24, 0, 1, 2, 4, 8'hAA, 8'h55);
    // cell 5 bit 7 cannot hold one: cell phase, complement pass
    f_caddr = 4'd5; f_cclr = 8'h80;
    run_case("cell5", 80, 0, 1, 3, 5, 8'hF9, 8'h79);
    // clean rerun after a failure clears the record
    run_case("rerun", 90, 0, 0, 0, 0, 0, 0);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) chk(0, "R6", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule